// File: doc/BRIEF.md
# Two-Register Serial Port

This block is a small asynchronous serial port for use where logic area matters more than features. Software sees two 16-bit words: a status/control word at word 0 (byte offset 0) and a data word at word 1 (byte offset 2). Seven divisor words follow at word addresses 2 to 8. A 3-bit speed index in the status word picks one of those divisors. Index 7 turns the port off. Each divisor sets the spacing of sample ticks, and every bit lasts eight ticks. With a 100 MHz clock, the divisor for a given rate is 100e6 / (8 x rate).

The port sends and receives 8-bit characters, or 9-bit characters when that mode is on. It can force a line BREAK and can detect an incoming one. Software can read the incoming clear-to-send level and drive a request-to-send output. It also sees a receive-overflow flag and a transmitter-empty flag. A transmit-enable output is high for the length of each outgoing frame, so it can steer a half-duplex line driver. Transmit has a one-character holding register ahead of the shifter. Receive has a single character register.

Top module: `twin_reg_uart`

## Requirements
- R1: Word 0 reads as: bit 0 transmit holding register free, bit 1 receive data ready, bit 2 receive overflow, bit 3 synchronised CTS level, bit 4 RTS, bits 7:5 speed index, bit 8 9-bit mode, bit 9 BREAK seen, bit 10 send BREAK, bit 12 transmitter fully empty, all other bits 0. After reset it reads 0x10E1 (speed index 7, idle).
- R2: Divisor words 2..8 belong to speed indices 0..6. They reset to the values for 115200, 57600, 38400, 19200, 9600, 4800 and 2400 baud from a 100 MHz clock (108, 217, 325, 651, 1302, 2604, 5208). They read back what was written.
- R3: With divisor d selected, a sample tick occurs every max(d,1) clocks and each serial bit lasts 8 ticks.
- R4: At speed index 7 the port is idle: TX stays high and a character written to DATA is held. It is sent once a valid index is selected.
- R5: A transmitted frame is one low start bit, then the data bits LSB first, then one high stop bit. Bit 0 of word 0 clears while a character waits in the holding register. Bit 12 sets only when nothing waits and nothing is shifting.
- R6: In 9-bit mode (word 0 bit 8), nine data bits are sent and received. The ninth bit is bit 8 of DATA.
- R7: A received character sets data-ready. Reading DATA returns it in bits 8:0 and clears data-ready.
- R8: If a character completes while data-ready is still set, it is discarded and the overflow flag is set. Reading word 0 clears the overflow and BREAK-seen flags.
- R9: A received frame whose data bits and stop bit are all zero sets BREAK-seen and does not set data-ready. The receiver then waits for the line to return high.
- R10: A falling edge on RX starts reception only if the line is still low at the middle of the start bit. A shorter low pulse is ignored.
- R11: While send BREAK (word 0 bit 10) is set, TX is low and no new frame starts. A character written during BREAK is sent after BREAK is cleared.
- R12: Word 0 bit 4 drives the RTS output. The CTS input appears in word 0 bit 3.
- R13: The transmit-enable output is high from the start of the start bit to the end of the stop bit, and low otherwise.
- R14: A write to DATA while the holding register is full is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_en | input | 1 | Register access strobe, one cycle per access |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | ADDR_W | Word address (0 status, 1 data, 2..8 divisors) |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr |
| ser_tx | output | 1 | Serial transmit line |
| ser_rx | input | 1 | Serial receive line |
| rts_o | output | 1 | Request-to-send output |
| cts_i | input | 1 | Clear-to-send input |
| tx_drive_en | output | 1 | High while a frame is on TX |

## Verification
The hardest case to reach is a character that completes while an earlier one is still unread. It has to overflow without disturbing the held character, and the overflow flag must then clear on the status read that reports it. The bench drives two whole frames onto RX back to back with no register access between them. It then reads status, data and status again, so the reporting read and the clearing read can each be checked. BREAK detection and the rejected short start pulse are reached the same way, by shaping the RX line directly with bit-accurate timing. On the transmit side, a queue of expected characters is compared against a line decoder that watches TX. That catches both lost frames and extra ones, including the write that should be dropped while the holding register is full.

// File: rtl/twin_reg_uart.sv
module twin_reg_uart #(
  parameter int CLK_HZ      = 100_000_000,
  parameter int DIV_W       = 16,
  parameter int ADDR_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_en,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [15:0]       reg_wdata,
  output logic [15:0]       reg_rdata,
  output logic              ser_tx,
  input  logic              ser_rx,
  output logic              rts_o,
  input  logic              cts_i,
  output logic              tx_drive_en
);
  localparam int NDIV = 7;
  localparam int OVS = 8;
  localparam logic [2:0] SPD_OFF = 3'd7;
  localparam logic [2:0] LAST_SUB = 3'(OVS - 1);
  localparam logic [2:0] MID_SUB = 3'(OVS / 2 - 2);

  typedef enum logic [2:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP, RX_HOLD} rx_st_t;

  function automatic logic [DIV_W-1:0] reset_div(input int idx);
    int rate;
    case (idx)
      0: rate = 115200;
      1: rate = 57600;
      2: rate = 38400;
      3: rate = 19200;
      4: rate = 9600;
      5: rate = 4800;
      default: rate = 2400;
    endcase
    return DIV_W'(CLK_HZ / (OVS * rate));
  endfunction

  logic [DIV_W-1:0] div_q [NDIV];
  logic [2:0] baud_q;
  logic rts_q, nine_q, tbreak_q;
  logic [SYNC_STAGES-1:0] rx_sync, cts_sync;

  wire rx_s = rx_sync[SYNC_STAGES-1];
  wire cts_s = cts_sync[SYNC_STAGES-1];
  wire stat_hit = reg_addr == ADDR_W'(0);
  wire data_hit = reg_addr == ADDR_W'(1);
  wire stat_wr = reg_en && reg_we && stat_hit;
  wire stat_rd = reg_en && !reg_we && stat_hit;
  wire data_wr = reg_en && reg_we && data_hit;
  wire data_rd = reg_en && !reg_we && data_hit;
  wire enabled = baud_q != SPD_OFF;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < NDIV; i++) div_q[i] <= reset_div(i);
      baud_q <= SPD_OFF;
      rts_q <= 1'b0;
      nine_q <= 1'b0;
      tbreak_q <= 1'b0;
    end else begin
      for (int i = 0; i < NDIV; i++)
        if (reg_en && reg_we && reg_addr == ADDR_W'(i + 2)) div_q[i] <= reg_wdata[DIV_W-1:0];
      if (stat_wr) begin
        rts_q <= reg_wdata[4];
        baud_q <= reg_wdata[7:5];
        nine_q <= reg_wdata[8];
        tbreak_q <= reg_wdata[10];
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_sync <= '1;
      cts_sync <= '0;
    end else begin
      rx_sync <= {rx_sync[SYNC_STAGES-2:0], ser_rx};
      cts_sync <= {cts_sync[SYNC_STAGES-2:0], cts_i};
    end

  logic [DIV_W-1:0] div_sel, tick_cnt;
  always_comb begin
    div_sel = '0;
    for (int i = 0; i < NDIV; i++)
      if (baud_q == 3'(i)) div_sel = div_q[i];
  end

  wire tick = enabled && ({1'b0, tick_cnt} + 1'b1 >= {1'b0, div_sel});

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) tick_cnt <= '0;
    else if (!enabled || tick) tick_cnt <= '0;
    else tick_cnt <= tick_cnt + 1'b1;

  logic [8:0] hold_q;
  logic hold_v, tx_busy;
  logic [10:0] tx_sh;
  logic [3:0] tx_left;
  logic [2:0] tx_sub;

  wire tx_start = enabled && hold_v && !tx_busy && !tbreak_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      hold_q <= '0;
      hold_v <= 1'b0;
    end else if (tx_start) hold_v <= 1'b0;
    else if (data_wr && !hold_v) begin
      hold_v <= 1'b1;
      hold_q <= reg_wdata[8:0];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tx_busy <= 1'b0;
      tx_sh <= '1;
      tx_left <= '0;
      tx_sub <= '0;
    end else if (!enabled) begin
      tx_busy <= 1'b0;
      tx_sub <= '0;
    end else if (tx_start) begin
      tx_busy <= 1'b1;
      tx_sub <= '0;
      tx_left <= nine_q ? 4'd11 : 4'd10;
      tx_sh <= nine_q ? {1'b1, hold_q, 1'b0} : {2'b11, hold_q[7:0], 1'b0};
    end else if (tx_busy && tick) begin
      if (tx_sub == LAST_SUB) begin
        tx_sub <= '0;
        tx_sh <= {1'b1, tx_sh[10:1]};
        tx_left <= tx_left - 1'b1;
        if (tx_left == 4'd1) tx_busy <= 1'b0;
      end else tx_sub <= tx_sub + 1'b1;
    end

  assign ser_tx = !tbreak_q && (!tx_busy || tx_sh[0]);
  assign tx_drive_en = tx_busy;
  assign rts_o = rts_q;

  rx_st_t rx_st;
  logic [2:0] rx_sub;
  logic [3:0] rx_cnt;
  logic [8:0] rx_sh, rx_data;
  logic dr_q, oerr_q, rbrk_q;

  wire [8:0] rx_word = nine_q ? rx_sh : {1'b0, rx_sh[8:1]};
  wire [3:0] rx_last = nine_q ? 4'd8 : 4'd7;
  wire stop_point = tick && rx_st == RX_STOP && rx_sub == LAST_SUB;
  wire rx_deliver = stop_point && rx_s;
  wire rx_brk = stop_point && !rx_s && rx_word == '0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_st <= RX_IDLE;
      rx_sub <= '0;
      rx_cnt <= '0;
      rx_sh <= '0;
    end else if (!enabled) begin
      rx_st <= RX_IDLE;
      rx_sub <= '0;
    end else begin
      case (rx_st)
        RX_IDLE:
          if (tick && !rx_s) begin
            rx_st <= RX_START;
            rx_sub <= '0;
          end
        RX_START:
          if (tick) begin
            if (rx_sub == MID_SUB) begin
              rx_st <= rx_s ? RX_IDLE : RX_DATA;
              rx_sub <= '0;
              rx_cnt <= '0;
            end else rx_sub <= rx_sub + 1'b1;
          end
        RX_DATA:
          if (tick) begin
            if (rx_sub == LAST_SUB) begin
              rx_sub <= '0;
              rx_sh <= {rx_s, rx_sh[8:1]};
              rx_cnt <= rx_cnt + 1'b1;
              if (rx_cnt == rx_last) rx_st <= RX_STOP;
            end else rx_sub <= rx_sub + 1'b1;
          end
        RX_STOP:
          if (tick) begin
            if (rx_sub == LAST_SUB) begin
              rx_sub <= '0;
              rx_st <= rx_s ? RX_IDLE : RX_HOLD;
            end else rx_sub <= rx_sub + 1'b1;
          end
        default:
          if (rx_s) rx_st <= RX_IDLE;
      endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      dr_q <= 1'b0;
      oerr_q <= 1'b0;
      rbrk_q <= 1'b0;
      rx_data <= '0;
    end else begin
      if (stat_rd) begin
        oerr_q <= 1'b0;
        rbrk_q <= 1'b0;
      end
      if (data_rd) dr_q <= 1'b0;
      if (rx_deliver) begin
        if (dr_q && !data_rd) oerr_q <= 1'b1;
        else begin
          dr_q <= 1'b1;
          rx_data <= rx_word;
        end
      end
      if (rx_brk) rbrk_q <= 1'b1;
    end

  wire tre = !hold_v && !tx_busy;
  wire [15:0] stat_word = {3'b000, tre, 1'b0, tbreak_q, rbrk_q, nine_q, baud_q,
                           rts_q, cts_s, oerr_q, dr_q, !hold_v};

  always_comb begin
    reg_rdata = '0;
    if (stat_hit) reg_rdata = stat_word;
    else if (data_hit) reg_rdata = {7'b0, rx_data};
    for (int i = 0; i < NDIV; i++)
      if (reg_addr == ADDR_W'(i + 2)) reg_rdata = 16'(div_q[i]);
  end
endmodule

// File: rtl/twin_reg_uart_sva.sv
module twin_reg_uart_sva #(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_en,
  input logic              reg_we,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              ser_tx,
  input logic              tx_drive_en,
  input logic [2:0]        baud_q,
  input logic              tbreak_q,
  input logic              tx_busy,
  input logic              dr_q,
  input logic              oerr_q,
  input logic              rx_deliver
);
  wire data_read = reg_en && !reg_we && reg_addr == ADDR_W'(1);

  a_r4_off_no_frame: assert property (@(posedge clk) disable iff (!rst_n)
    (baud_q == 3'd7) |=> !tx_drive_en);

  a_r13_idle_line_high: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_drive_en && !tbreak_q) |-> ser_tx);

  a_r11_no_start_in_break: assert property (@(posedge clk) disable iff (!rst_n)
    (tbreak_q && !tx_busy) |=> !tx_busy);

  a_r8_overflow_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oerr_q) |-> dr_q);

  a_r7_read_clears_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (data_read && !rx_deliver) |=> !dr_q);

  a_r7_ready_from_frame: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dr_q) |-> $past(rx_deliver));
endmodule

bind twin_reg_uart twin_reg_uart_sva #(.ADDR_W(ADDR_W)) u_sva (
  .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_we(reg_we), .reg_addr(reg_addr),
  .ser_tx(ser_tx), .tx_drive_en(tx_drive_en), .baud_q(baud_q), .tbreak_q(tbreak_q),
  .tx_busy(tx_busy), .dr_q(dr_q), .oerr_q(oerr_q), .rx_deliver(rx_deliver)
);

// File: tb/twin_reg_uart_tb_top.sv
`timescale 1ns/1ps
module twin_reg_uart_tb_top;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0;
  logic reg_en = 1'b0, reg_we = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [15:0] reg_wdata = '0, reg_rdata;
  logic ser_tx, rts_o, tx_drive_en;
  logic drv_rx = 1'b1, cts_i = 1'b0;

  twin_reg_uart dut_i (
    .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ser_tx(ser_tx), .ser_rx(drv_rx),
    .rts_o(rts_o), .cts_i(cts_i), .tx_drive_en(tx_drive_en)
  );

  int n_chk = 0, n_fail = 0, frames = 0;
  int bit_ns = 80, mon_bits = 8;
  bit mon_on = 1'b1, done = 1'b0;
  logic [8:0] exp_q[$];
  logic [15:0] v;

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [15:0] d);
    @(negedge clk);
    reg_en = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_en = 1'b0; reg_we = 1'b0;
    @(negedge clk);
  endtask

  task automatic rd(logic [3:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_en = 1'b1; reg_we = 1'b0; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic send(logic [8:0] d);
    exp_q.push_back(d);
    wr(4'd1, {7'b0, d});
  endtask

  task automatic wait_tx_idle();
    logic [15:0] s;
    for (int k = 0; k < 2000; k++) begin
      rd(4'd0, s);
      if (s[12]) break;
    end
    #(bit_ns);
  endtask

  task automatic rx_frame(logic [8:0] d, int n, logic stopb);
    drv_rx = 1'b0; #(bit_ns);
    for (int i = 0; i < n; i++) begin drv_rx = d[i]; #(bit_ns); end
    drv_rx = stopb; #(bit_ns);
    drv_rx = 1'b1; #(bit_ns);
  endtask

  // monitor: decodes TX and compares against the expected queue
  initial forever begin
    logic [8:0] got;
    @(negedge ser_tx);
    if (mon_on) begin
      got = '0;
      #(bit_ns / 2);
      check("R5 start bit", {15'b0, ser_tx}, 16'h0);
      check("R13 enable in start", {15'b0, tx_drive_en}, 16'h1);
      for (int i = 0; i < mon_bits; i++) begin #(bit_ns); got[i] = ser_tx; end
      #(bit_ns);
      check("R5 stop bit", {15'b0, ser_tx}, 16'h1);
      check("R13 enable in stop", {15'b0, tx_drive_en}, 16'h1);
      frames++;
      if (exp_q.size() == 0) check("R14 unexpected frame", {7'b0, got}, 16'hFFFF);
      else check("R5/R6 frame data", {7'b0, got}, {7'b0, exp_q.pop_front()});
    end
  end

  initial begin
    #(500_000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    rd(4'd0, v); check("R1 reset status", v, 16'h10E1);
    check("R13 idle enable low", {15'b0, tx_drive_en}, 16'h0);
    rd(4'd2, v); check("R2 default div0", v, 16'd108);
    rd(4'd5, v); check("R2 default div3", v, 16'd651);
    rd(4'd8, v); check("R2 default div6", v, 16'd5208);
    wr(4'd2, 16'd2);
    rd(4'd2, v); check("R2 div readback", v, 16'd2);

    send(9'h055);
    repeat (200) @(negedge clk);
    check("R4 off line high", {15'b0, ser_tx}, 16'h1);
    rd(4'd0, v); check("R4 char held", v & 16'h1001, 16'h0000);
    wr(4'd0, 16'h0000);
    wait_tx_idle();
    check("R4 sent after enable", 16'(exp_q.size()), 16'd0);

    send(9'h0A3);
    send(9'h000);
    rd(4'd0, v); check("R5 holding full", v & 16'h1001, 16'h0000);
    wr(4'd1, 16'h00FF);
    wait_tx_idle();
    wait_tx_idle();
    check("R14 dropped write", 16'(frames), 16'd3);
    rd(4'd0, v); check("R5 empty flags", v & 16'h1001, 16'h1001);

    mon_bits = 9;
    wr(4'd0, 16'h0100);
    send(9'h1A5);
    wait_tx_idle();
    mon_bits = 8;
    wr(4'd0, 16'h0000);

    wr(4'd3, 16'd4);
    wr(4'd0, 16'h0020);
    bit_ns = 160;
    send(9'h05A);
    wait_tx_idle();
    bit_ns = 80;
    wr(4'd0, 16'h0000);
    check("R3 frames at two rates", 16'(frames), 16'd5);

    mon_on = 1'b0;
    wr(4'd0, 16'h0400);
    repeat (5) @(negedge clk);
    check("R11 break low", {15'b0, ser_tx}, 16'h0);
    exp_q.push_back(9'h0C3);
    wr(4'd1, 16'h00C3);
    repeat (200) @(negedge clk);
    check("R11 no start in break", {15'b0, tx_drive_en}, 16'h0);
    mon_on = 1'b1;
    wr(4'd0, 16'h0000);
    wait_tx_idle();
    check("R11 sent after break", 16'(exp_q.size()), 16'd0);

    wr(4'd0, 16'h0010);
    check("R12 rts out", {15'b0, rts_o}, 16'h1);
    cts_i = 1'b1;
    repeat (4) @(negedge clk);
    rd(4'd0, v); check("R12 cts in", {15'b0, v[3]}, 16'h1);
    cts_i = 1'b0;
    wr(4'd0, 16'h0000);

    rx_frame(9'h03C, 8, 1'b1);
    rd(4'd0, v); check("R7 ready set", {15'b0, v[1]}, 16'h1);
    rd(4'd1, v); check("R7 data", v, 16'h003C);
    rd(4'd0, v); check("R7 ready cleared", {15'b0, v[1]}, 16'h0);

    rx_frame(9'h011, 8, 1'b1);
    rx_frame(9'h022, 8, 1'b1);
    rd(4'd0, v); check("R8 overflow and ready", {14'b0, v[2:1]}, 16'h3);
    rd(4'd1, v); check("R8 first kept", v, 16'h0011);
    rd(4'd0, v); check("R8 flags cleared", {14'b0, v[2:1]}, 16'h0);

    wr(4'd0, 16'h0100);
    rx_frame(9'h155, 9, 1'b1);
    rd(4'd1, v); check("R6 nine-bit receive", v, 16'h0155);
    wr(4'd0, 16'h0000);

    drv_rx = 1'b0;
    #(bit_ns * 12);
    drv_rx = 1'b1;
    #(bit_ns * 2);
    rd(4'd0, v); check("R9 break seen, no data", {6'b0, v[9], 8'b0, v[1]}, 16'h0200);
    rd(4'd0, v); check("R9 break flag read-cleared", {15'b0, v[9]}, 16'h0);

    @(negedge clk);
    drv_rx = 1'b0;
    repeat (3) @(negedge clk);
    drv_rx = 1'b1;
    #(bit_ns * 4);
    rd(4'd0, v); check("R10 short pulse ignored", {6'b0, v[9], 8'b0, v[1]}, 16'h0);
    rx_frame(9'h081, 8, 1'b1);
    rd(4'd1, v); check("R10 receiver still aligned", v, 16'h0081);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule